// File: doc/BRIEF.md
# Processor reset vector fetch sequencer

This block brings a processor core out of reset. While reset is held it forces the architectural state to its start-up values. The status word comes up in supervisor mode with the interrupt mask at its top level and tracing off. The vector base is zero, and every enable for a directly attached memory (cache or local RAM) is off. On the first clock after reset is released it copies two hardware configuration words into the data-register outputs. It then requests the bus and, once the bus is granted, runs three 32-bit reads:

- the initial stack pointer, from address 0;
- the initial program counter, from address 4;
- the first instruction, from the program counter address just loaded.

When that fetch completes, the core is marked as running.

Any error response during these three reads halts the block. So does an odd program counter. While the core runs, a fault that arrives while an earlier fault is still being handled also halts it. The halted state holds the bus idle, and only reset leaves it. Reset has priority over everything and abandons any read in progress.

Top module: `reset_vector_sequencer`

## Requirements
- R1: Reset (rst_n low at a clock edge) takes priority over every other input. After that edge bus_req and rd_valid are 0, any read in progress is abandoned, and the sequence restarts from the stack pointer read once rst_n is high again.
- R2: After a reset edge, sr_out is 0x2700: supervisor bit 13 set, trace bit 15 clear, master bit 12 clear, interrupt mask bits 10:8 equal to 7, and all other bits 0.
- R3: After a reset edge, vbr_out is 0x00000000 and every bit of mem_en is 0.
- R4: At the first clock edge with rst_n high, d0_out and d1_out take cfg_word0 and cfg_word1.
- R5: From the second cycle after reset release, bus_req is 1 until the first fetch completes. No read is issued before a cycle in which bus_gnt was sampled 1.
- R6: The first read uses rd_addr 0 and loads sp_out. The second uses rd_addr 4 and loads pc_out. Each read completes on a cycle in which rd_ack is 1 and rd_err is 0.
- R7: The third read uses rd_addr equal to pc_out. On its acknowledge, first_insn takes rd_rdata, running goes to 1, and bus_req drops.
- R8: rd_err high on any of the three start-up reads halts the block. A program counter word with bit 0 set halts it without issuing the fetch. rd_err wins over rd_ack in the same cycle.
- R9: While running, the first fault_in pulse opens fault handling and exc_done closes it. A fault_in in a cycle where handling is still open halts the block, even when exc_done is high in that same cycle. fault_in before running has no effect.
- R10: Once halted, halted stays 1 and bus_req, rd_valid and running stay 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | output | 1 | Bus request during start-up |
| bus_gnt | input | 1 | Bus grant |
| rd_valid | output | 1 | Read cycle active |
| rd_addr | output | 32 | Read address |
| rd_rdata | input | 32 | Read data |
| rd_ack | input | 1 | Read completed |
| rd_err | input | 1 | Read ended with access or address error |
| cfg_word0 | input | 32 | Hardware configuration word for D0 |
| cfg_word1 | input | 32 | Hardware configuration word for D1 |
| fault_in | input | 1 | Fault reported by the core while running |
| exc_done | input | 1 | Current fault's exception handling finished |
| sr_out | output | 16 | Status register |
| vbr_out | output | 32 | Vector base register |
| sp_out | output | 32 | Initial stack pointer |
| pc_out | output | 32 | Initial program counter |
| d0_out | output | 32 | Data register 0 |
| d1_out | output | 32 | Data register 1 |
| first_insn | output | 32 | First instruction word fetched |
| mem_en | output | 2 | Attached memory enables |
| running | output | 1 | Start-up complete, core executing |
| halted | output | 1 | Fault-on-fault halt |

## Verification
Two events can fall in the same cycle: the end of one fault's handling (exc_done) and the arrival of a new fault (fault_in). The bench drives both high together on one clock while handling is open. The behavioural model requires a halt there, and the design is compared against the model on every clock. A bus error can also coincide with an acknowledge. The error responder asserts rd_ack and rd_err together, and the model requires the error to win.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_REQ,
      ST_RD_SP,
      ST_RD_PC,
      ST_FETCH,
      ST_RUN,
      ST_HALT
   } rvs_state_e;

   localparam int SR_W       = 16;
   localparam int SR_T_BIT   = 15;
   localparam int SR_S_BIT   = 13;
   localparam int SR_M_BIT   = 12;
   localparam int SR_IPL_LSB = 8;
   localparam int SR_IPL_W   = 3;

   function automatic logic [SR_W-1:0] sr_reset_value(input int ipl);
      logic [SR_W-1:0] v;
      v = '0;
      v[SR_S_BIT] = 1'b1;
      v[SR_T_BIT] = 1'b0;
      v[SR_M_BIT] = 1'b0;
      v[SR_IPL_LSB +: SR_IPL_W] = SR_IPL_W'(ipl);
      return v;
   endfunction

endpackage

// File: rtl/rvs_fault.sv
module rvs_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic running,
   input  logic fault_in,
   input  logic exc_done,
   output logic busy,
   output logic fof
);

   logic busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (running) begin
         if (fault_in)      busy_q <= 1'b1;
         else if (exc_done) busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign fof  = running & fault_in & busy_q;

endmodule

// File: rtl/rvs_regs.sv
module rvs_regs
   import rvs_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int N_MEM      = 2,
   parameter int IPL_RESET  = 7,
   parameter int INSN_ALIGN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_cfg,
   input  logic              ld_sp,
   input  logic              ld_pc,
   input  logic              ld_insn,
   input  logic [WORD_W-1:0] rd_rdata,
   input  logic [WORD_W-1:0] cfg_word0,
   input  logic [WORD_W-1:0] cfg_word1,
   output logic [SR_W-1:0]   sr_q,
   output logic [WORD_W-1:0] vbr_q,
   output logic [WORD_W-1:0] sp_q,
   output logic [WORD_W-1:0] pc_q,
   output logic [WORD_W-1:0] d0_q,
   output logic [WORD_W-1:0] d1_q,
   output logic [WORD_W-1:0] insn_q,
   output logic [N_MEM-1:0]  mem_en_q,
   output logic              pc_misaligned
);

   localparam int ALIGN_BITS = $clog2(INSN_ALIGN);
   localparam logic [SR_W-1:0] SR_RST = sr_reset_value(IPL_RESET);

   if ((INSN_ALIGN < 1) || ((INSN_ALIGN & (INSN_ALIGN - 1)) != 0)) begin : g_bad_align
      $error("INSN_ALIGN must be a power of two");
   end
   if (ALIGN_BITS >= WORD_W) begin : g_bad_align_w
      $error("INSN_ALIGN too large for WORD_W");
   end

   // Status register: only reset writes it in this block
   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= SR_RST;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) vbr_q <= '0;
   end

   // One disable flop per attached memory
   for (genvar m = 0; m < N_MEM; m++) begin : g_mem
      always_ff @(posedge clk) begin
         if (!rst_n) mem_en_q[m] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q   <= '0;
         pc_q   <= '0;
         d0_q   <= '0;
         d1_q   <= '0;
         insn_q <= '0;
      end else begin
         if (ld_cfg) begin
            d0_q <= cfg_word0;
            d1_q <= cfg_word1;
         end
         if (ld_sp)   sp_q   <= rd_rdata;
         if (ld_pc)   pc_q   <= rd_rdata;
         if (ld_insn) insn_q <= rd_rdata;
      end
   end

   if (ALIGN_BITS > 0) begin : g_align_chk
      assign pc_misaligned = |rd_rdata[ALIGN_BITS-1:0];
   end else begin : g_no_align_chk
      assign pc_misaligned = 1'b0;
   end

   AST_SR_RESET_VALUE: assert property (@(posedge clk) !rst_n |=> (sr_q == SR_RST)); // R2
   AST_VBR_MEM_CLEAR: assert property (@(posedge clk) !rst_n |=> ((vbr_q == '0) && (mem_en_q == '0))); // R3

endmodule

// File: rtl/rvs_fsm.sv
module rvs_fsm
   import rvs_pkg::*;
#(
   parameter int          WORD_W      = 32,
   parameter int unsigned SP_VEC_ADDR = 0,
   parameter int unsigned PC_VEC_ADDR = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_gnt,
   input  logic              rd_ack,
   input  logic              rd_err,
   input  logic              pc_misaligned,
   input  logic              fof,
   input  logic [WORD_W-1:0] pc_q,
   output logic              bus_req,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_addr,
   output logic              ld_cfg,
   output logic              ld_sp,
   output logic              ld_pc,
   output logic              ld_insn,
   output logic              running,
   output logic              halted
);

   rvs_state_e state_q, state_d;
   logic       rd_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_BOOT;
      else        state_q <= state_d;
   end

   assign rd_ok = rd_ack & ~rd_err;

   always_comb begin
      state_d = state_q;
      ld_cfg  = 1'b0;
      ld_sp   = 1'b0;
      ld_pc   = 1'b0;
      ld_insn = 1'b0;
      unique case (state_q)
         ST_BOOT: begin
            ld_cfg  = 1'b1;
            state_d = ST_REQ;
         end
         ST_REQ: begin
            if (bus_gnt) state_d = ST_RD_SP;
         end
         ST_RD_SP: begin
            if (rd_err) state_d = ST_HALT;
            else if (rd_ok) begin
               ld_sp   = 1'b1;
               state_d = ST_RD_PC;
            end
         end
         ST_RD_PC: begin
            if (rd_err) state_d = ST_HALT;
            else if (rd_ok) begin
               ld_pc   = 1'b1;
               state_d = pc_misaligned ? ST_HALT : ST_FETCH;
            end
         end
         ST_FETCH: begin
            if (rd_err) state_d = ST_HALT;
            else if (rd_ok) begin
               ld_insn = 1'b1;
               state_d = ST_RUN;
            end
         end
         ST_RUN: begin
            if (fof) state_d = ST_HALT;
         end
         ST_HALT: state_d = ST_HALT;
         default: state_d = ST_HALT;
      endcase
   end

   always_comb begin
      rd_addr = '0;
      unique case (state_q)
         ST_RD_SP: rd_addr = WORD_W'(SP_VEC_ADDR);
         ST_RD_PC: rd_addr = WORD_W'(PC_VEC_ADDR);
         ST_FETCH: rd_addr = pc_q;
         default:  rd_addr = '0;
      endcase
   end

   assign bus_req  = (state_q == ST_REQ) || (state_q == ST_RD_SP) ||
                     (state_q == ST_RD_PC) || (state_q == ST_FETCH);
   assign rd_valid = (state_q == ST_RD_SP) || (state_q == ST_RD_PC) ||
                     (state_q == ST_FETCH);
   assign running  = (state_q == ST_RUN);
   assign halted   = (state_q == ST_HALT);

   AST_RESET_ABORTS: assert property (@(posedge clk) !rst_n |=> (!bus_req && !rd_valid)); // R1
   AST_READ_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $past(bus_gnt)); // R5
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !bus_req && !rd_valid)); // R10

endmodule

// File: rtl/reset_vector_sequencer.sv
module reset_vector_sequencer
   import rvs_pkg::*;
#(
   parameter int          WORD_W      = 32,
   parameter int          N_MEM       = 2,
   parameter int          IPL_RESET   = 7,
   parameter int          INSN_ALIGN  = 2,
   parameter int unsigned SP_VEC_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_addr,
   input  logic [WORD_W-1:0] rd_rdata,
   input  logic              rd_ack,
   input  logic              rd_err,
   input  logic [WORD_W-1:0] cfg_word0,
   input  logic [WORD_W-1:0] cfg_word1,
   input  logic              fault_in,
   input  logic              exc_done,
   output logic [SR_W-1:0]   sr_out,
   output logic [WORD_W-1:0] vbr_out,
   output logic [WORD_W-1:0] sp_out,
   output logic [WORD_W-1:0] pc_out,
   output logic [WORD_W-1:0] d0_out,
   output logic [WORD_W-1:0] d1_out,
   output logic [WORD_W-1:0] first_insn,
   output logic [N_MEM-1:0]  mem_en,
   output logic              running,
   output logic              halted
);

   localparam int unsigned PC_VEC_ADDR = SP_VEC_ADDR + WORD_W / 8;

   if ((WORD_W < SR_W) || ((WORD_W % 8) != 0)) begin : g_bad_word
      $error("WORD_W must be a byte multiple of at least 16");
   end
   if ((IPL_RESET < 0) || (IPL_RESET >= (1 << SR_IPL_W))) begin : g_bad_ipl
      $error("IPL_RESET out of range");
   end
   if (N_MEM < 1) begin : g_bad_mem
      $error("N_MEM must be at least 1");
   end

   logic ld_cfg, ld_sp, ld_pc, ld_insn;
   logic pc_misaligned, fof, fault_busy;

   rvs_fsm #(
      .WORD_W      (WORD_W),
      .SP_VEC_ADDR (SP_VEC_ADDR),
      .PC_VEC_ADDR (PC_VEC_ADDR)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_gnt       (bus_gnt),
      .rd_ack        (rd_ack),
      .rd_err        (rd_err),
      .pc_misaligned (pc_misaligned),
      .fof           (fof),
      .pc_q          (pc_out),
      .bus_req       (bus_req),
      .rd_valid      (rd_valid),
      .rd_addr       (rd_addr),
      .ld_cfg        (ld_cfg),
      .ld_sp         (ld_sp),
      .ld_pc         (ld_pc),
      .ld_insn       (ld_insn),
      .running       (running),
      .halted        (halted)
   );

   rvs_regs #(
      .WORD_W     (WORD_W),
      .N_MEM      (N_MEM),
      .IPL_RESET  (IPL_RESET),
      .INSN_ALIGN (INSN_ALIGN)
   ) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .ld_cfg        (ld_cfg),
      .ld_sp         (ld_sp),
      .ld_pc         (ld_pc),
      .ld_insn       (ld_insn),
      .rd_rdata      (rd_rdata),
      .cfg_word0     (cfg_word0),
      .cfg_word1     (cfg_word1),
      .sr_q          (sr_out),
      .vbr_q         (vbr_out),
      .sp_q          (sp_out),
      .pc_q          (pc_out),
      .d0_q          (d0_out),
      .d1_q          (d1_out),
      .insn_q        (first_insn),
      .mem_en_q      (mem_en),
      .pc_misaligned (pc_misaligned)
   );

   rvs_fault u_fault (
      .clk      (clk),
      .rst_n    (rst_n),
      .running  (running),
      .fault_in (fault_in),
      .exc_done (exc_done),
      .busy     (fault_busy),
      .fof      (fof)
   );

   AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |=> ((d0_out == $past(cfg_word0)) && (d1_out == $past(cfg_word1)))); // R4
   AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(rd_valid && rd_ack && !rd_err && (rd_addr == pc_out))); // R7
   AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_err) |=> halted); // R8
   AST_FOF_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (running && fault_in && fault_busy) |=> halted); // R9
   AST_FIRST_FAULT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (running && fault_in && !fault_busy) |=> running); // R9

endmodule

// File: tb/test_reset_vector_sequencer.sv
module test_reset_vector_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req, bus_gnt = 1'b0;
   logic        rd_valid;
   logic [31:0] rd_addr;
   logic [31:0] rd_rdata = '0;
   logic        rd_ack = 1'b0, rd_err = 1'b0;
   logic [31:0] cfg_word0 = 32'hCF01_0234, cfg_word1 = 32'h0000_5A5A;
   logic        fault_in = 1'b0, exc_done = 1'b0;
   logic [15:0] sr_out;
   logic [31:0] vbr_out, sp_out, pc_out, d0_out, d1_out, first_insn;
   logic [1:0]  mem_en;
   logic        running, halted;

   reset_vector_sequencer i_reset_vector_sequencer (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_rdata(rd_rdata),
      .rd_ack(rd_ack), .rd_err(rd_err), .cfg_word0(cfg_word0),
      .cfg_word1(cfg_word1), .fault_in(fault_in), .exc_done(exc_done),
      .sr_out(sr_out), .vbr_out(vbr_out), .sp_out(sp_out), .pc_out(pc_out),
      .d0_out(d0_out), .d1_out(d1_out), .first_insn(first_insn),
      .mem_en(mem_en), .running(running), .halted(halted)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   // memory image and responder controls
   logic [31:0] m_sp = 32'h0001_0000, m_pc = 32'h0000_0400, m_insn = 32'h4E71_2468;
   int          gnt_delay = 3;
   int          gcnt = 0;
   bit          slow = 1'b0, tog = 1'b0;
   bit          err_en = 1'b0;
   logic [31:0] err_addr = '0;

   // behavioural reference: 0 boot,1 req,2 sp,3 pc,4 fetch,5 run,6 halt
   int          ms = 0;
   bit          mbusy = 1'b0;
   logic [31:0] msp = '0, mpc = '0, md0 = '0, md1 = '0, mins = '0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         ms = 0; mbusy = 1'b0;
         msp = '0; mpc = '0; md0 = '0; md1 = '0; mins = '0;
      end else begin
         case (ms)
            0: begin md0 = cfg_word0; md1 = cfg_word1; ms = 1; end
            1: if (bus_gnt) ms = 2;
            2: if (rd_err) ms = 6; else if (rd_ack) begin msp = rd_rdata; ms = 3; end
            3: if (rd_err) ms = 6;
               else if (rd_ack) begin mpc = rd_rdata; ms = rd_rdata[0] ? 6 : 4; end
            4: if (rd_err) ms = 6; else if (rd_ack) begin mins = rd_rdata; ms = 5; end
            5: if (fault_in) begin
                  if (mbusy) ms = 6; else mbusy = 1'b1;
               end else if (exc_done) mbusy = 1'b0;
            default: ms = 6;
         endcase
      end
      if (cyc >= WATCHDOG && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL R10 watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // compare every cycle, then act as bus arbiter and memory
   always @(negedge clk) begin
      logic [31:0] e_addr;
      if (cyc > 0 && !done) begin
         e_addr = (ms == 3) ? 32'd4 : (ms == 4) ? mpc : 32'd0;
         check(bus_req == (ms >= 1 && ms <= 4), "R5 bus_req", {31'd0, bus_req}, {31'd0, ms >= 1 && ms <= 4});
         check(rd_valid == (ms >= 2 && ms <= 4), "R6 rd_valid", {31'd0, rd_valid}, {31'd0, ms >= 2 && ms <= 4});
         if (ms >= 2 && ms <= 4) check(rd_addr == e_addr, "R6 rd_addr", rd_addr, e_addr);
         check(halted == (ms == 6), "R10 halted", {31'd0, halted}, {31'd0, ms == 6});
         check(running == (ms == 5), "R7 running", {31'd0, running}, {31'd0, ms == 5});
         check(sr_out == 16'h2700, "R2 sr", {16'd0, sr_out}, 32'h2700);
         check(vbr_out == 0 && mem_en == 0, "R3 vbr/mem_en", vbr_out | {30'd0, mem_en}, 32'd0);
         check(sp_out == msp, "R6 sp", sp_out, msp);
         check(pc_out == mpc, "R6 pc", pc_out, mpc);
         check(d0_out == md0 && d1_out == md1, "R4 d0/d1", d0_out ^ d1_out, md0 ^ md1);
         check(first_insn == mins, "R7 first_insn", first_insn, mins);
      end
      if (bus_req) gcnt++; else gcnt = 0;
      bus_gnt = bus_req && (gcnt > gnt_delay);
      tog = ~tog;
      rd_ack = rd_valid && (!slow || tog);
      rd_err = rd_valid && err_en && (rd_addr == err_addr);
      rd_rdata = (rd_addr == 32'd0) ? m_sp : (rd_addr == 32'd4) ? m_pc : m_insn;
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cycles(3);
      check(sr_out == 16'h2700, "R2 sr in reset", {16'd0, sr_out}, 32'h2700);
      check(vbr_out == 0, "R3 vbr in reset", vbr_out, 32'd0);
      check(!bus_req && !rd_valid && !halted, "R1 bus idle in reset", {29'd0, bus_req, rd_valid, halted}, 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic wait_run();
      for (int i = 0; i < 300 && !running && !halted; i++) @(negedge clk);
   endtask

   task automatic pulse_fault();
      @(negedge clk); fault_in = 1'b1;
      @(negedge clk); fault_in = 1'b0;
   endtask

   initial begin
      // normal start-up with a delayed grant
      do_reset();
      @(negedge clk);
      check(d0_out == cfg_word0, "R4 d0 capture", d0_out, cfg_word0);
      check(d1_out == cfg_word1, "R4 d1 capture", d1_out, cfg_word1);
      wait_run();
      check(running, "R7 started", {31'd0, running}, 32'd1);
      check(sp_out == m_sp && pc_out == m_pc, "R6 vectors", sp_out, m_sp);
      check(first_insn == m_insn && !bus_req, "R7 fetch", first_insn, m_insn);
      // faults that are closed before the next one do not halt
      pulse_fault();
      cycles(2);
      @(negedge clk); exc_done = 1'b1;
      @(negedge clk); exc_done = 1'b0;
      pulse_fault();
      cycles(1);
      check(running && !halted, "R9 single fault", {31'd0, running}, 32'd1);
      pulse_fault();
      check(halted, "R9 fault on fault", {31'd0, halted}, 32'd1);
      cycles(10);
      check(halted && !bus_req && !running, "R10 halt held", {30'd0, halted, bus_req}, 32'd2);

      // fault and end of handling in the same cycle, slow memory
      slow = 1'b1; gnt_delay = 0;
      do_reset();
      wait_run();
      check(running, "R6 slow start", {31'd0, running}, 32'd1);
      pulse_fault();
      @(negedge clk); fault_in = 1'b1; exc_done = 1'b1;
      @(negedge clk); fault_in = 1'b0; exc_done = 1'b0;
      check(halted, "R9 same-cycle fault and done", {31'd0, halted}, 32'd1);

      // faults during start-up are ignored
      slow = 1'b0;
      do_reset();
      fault_in = 1'b1;
      cycles(5);
      fault_in = 1'b0;
      wait_run();
      pulse_fault();
      cycles(1);
      check(running && !halted, "R9 boot faults ignored", {31'd0, running}, 32'd1);

      // reset in the middle of the program counter read
      slow = 1'b1; gnt_delay = 2;
      do_reset();
      for (int i = 0; i < 100 && !(rd_valid && rd_addr == 32'd4); i++) @(negedge clk);
      rst_n = 1'b0;
      cycles(2);
      check(!rd_valid && !bus_req, "R1 read abandoned", {30'd0, rd_valid, bus_req}, 32'd0);
      rst_n = 1'b1;
      wait_run();
      check(running && sp_out == m_sp, "R1 restart", sp_out, m_sp);

      // odd program counter
      slow = 1'b0; m_pc = 32'h0000_0401;
      do_reset();
      cycles(30);
      check(halted && pc_out == m_pc, "R8 odd pc halts", pc_out, m_pc);

      // error on stack pointer read, with ack also high
      m_pc = 32'h0000_0400; err_en = 1'b1; err_addr = 32'd0;
      do_reset();
      cycles(20);
      check(halted && sp_out == 0, "R8 sp read error", sp_out, 32'd0);

      // error on the instruction fetch
      err_addr = 32'h0000_0400;
      do_reset();
      cycles(20);
      check(halted && !running && first_insn == 0, "R8 fetch error", first_insn, 32'd0);

      // reset leaves the halted state
      err_en = 1'b0;
      do_reset();
      wait_run();
      check(running && !halted, "R10 reset exits halt", {30'd0, running, halted}, 32'd2);

      cycles(3);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule